// File: doc/BRIEF.md
# SPI-to-Parallel Register Bridge

This block is an SPI slave that gives an external SPI host indirect access to a 16-bit parallel register bus. The host first loads a target location into bridge registers. These hold the low address word, the high address byte and a small chip-select field. The host then moves data through a data-port register. A write to the data port issues one parallel write. A read of the data port issues one parallel read, and its result is returned in the following SPI frame, so fresh data takes two consecutive data-port reads. The address and chip-select registers keep their contents between frames, so repeated traffic to one location needs only data-port frames.

Every frame is bounded by the chip select going low and then high, and carries three bytes. The first is a command byte, then the data low byte, then the data high byte. One reply byte is shifted out for each byte received. On the parallel side the bridge is a valid/ready style master. `bus_req` is the valid signal and `bus_done` is the ready signal. Once `bus_req` rises, the bridge holds it and all bus outputs steady until the bus answers with `bus_done`, so the bus may stall for any number of cycles. A data-port frame that completes while a bus cycle is still outstanding is dropped, and the host must space its frames to cover the bus latency. SPI pins pass through two-stage synchronizers, so the system clock must run several times faster than the SPI clock.

Top module: `spi_regbridge`

## Requirements
- R1: After reset `bus_req` and `miso` are low, and the three bridge registers and the read holding register are zero.
- R2: In the command byte, bits [1:0] select a bridge register (0 address low, 1 address high, 2 chip-select, 3 data port) and bit 3 sets the direction (1 read, 0 write). The remaining command bits have no effect.
- R3: Register 0 stores 16 bits, register 1 stores 8 bits and register 2 stores 2 bits. Reading any of them returns its current contents zero-extended to 16 bits.
- R4: The serial format is SPI mode 0. `mosi` is sampled on the rising `sclk` edge, and `miso` changes only after a falling edge. Each byte travels most significant bit first, and 16-bit data travels low byte first in both directions.
- R5: A write frame to register 3 issues exactly one bus write. It has `bus_we`=1, `bus_addr`={register 1, register 0}, `bus_sel`=register 2 and `bus_wdata` equal to the frame data.
- R6: A read frame to register 3 issues exactly one bus read (`bus_we`=0) at the latched location after the frame ends. The data reply of any register-3 frame is the result of the most recent completed bus read, which is 0 after reset.
- R7: The address and chip-select registers persist across frames, so later data-port frames reuse them.
- R8: A frame carrying fewer or more than three bytes is discarded. It updates no register and starts no bus cycle.
- R9: While `bus_req` is high and `bus_done` is low, `bus_req`, `bus_we`, `bus_addr`, `bus_sel` and `bus_wdata` hold steady. `bus_req` falls in the cycle after `bus_done`.
- R10: The byte returned during the command phase is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Active-low frame select from the host |
| spi_miso | output | 1 | Serial reply data to the host |
| bus_req | output | 1 | Parallel cycle valid, held until done |
| bus_we | output | 1 | 1 for a write cycle, 0 for a read cycle |
| bus_addr | output | ADDR_HI_W+16 | Parallel address |
| bus_sel | output | SEL_W | Parallel chip-select field |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, sampled with bus_done |
| bus_done | input | 1 | Parallel cycle accepted and finished |

## Verification
The bench builds the bridge with its default parameters: an 8-bit high address byte, a 2-bit chip-select field and two synchronizer stages. With these values the full 24-bit address is reachable, and so is the truncation of wide writes to the high-address and chip-select registers. The SPI host model runs 16 system clocks per serial bit. The parallel bus model answers after three cycles and returns data derived from the address and chip select, so each of them shows up in the reply. That latency makes the one-frame lag of data-port reads visible, and it exercises the hold-until-done rule on every bus cycle.

// File: rtl/spi_regbridge_pkg.sv
package spi_regbridge_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;
  localparam int DIR_BIT = 3;
  localparam int FRAME_BYTES = 3;

  typedef enum logic [1:0] {
    BREG_ADDR_LO = 2'd0,
    BREG_ADDR_HI = 2'd1,
    BREG_BANK    = 2'd2,
    BREG_PORT    = 2'd3
  } breg_e;
endpackage

// File: rtl/spi_regbridge_sync.sv
module spi_regbridge_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[CHAIN_W-W-1:0], d};
  end

  assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/spi_regbridge_shifter.sv
module spi_regbridge_shifter
  import spi_regbridge_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic              cs_n_s,
  input  logic [WORD_W-1:0] reply_word,
  output logic              miso,
  output logic [1:0]        cur_reg,
  output logic              frame_valid,
  output logic [1:0]        frame_reg,
  output logic              frame_rd,
  output logic [WORD_W-1:0] frame_data
);
  logic              sclk_q, cs_q;
  logic [2:0]        bit_cnt;
  logic [2:0]        byte_cnt;
  logic [BYTE_W-2:0] rx_sh;
  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] rx_byte;
  logic [BYTE_W-1:0] lo_q, hi_q;
  logic [1:0]        reg_q;
  logic              rd_q;
  logic              rise, fall, active, cs_fall, cs_rise;

  assign rise    = sclk_s & ~sclk_q;
  assign fall    = ~sclk_s & sclk_q;
  assign active  = ~cs_n_s;
  assign cs_fall = cs_q & ~cs_n_s;
  assign cs_rise = ~cs_q & cs_n_s;
  assign rx_byte = {rx_sh, mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q      <= 1'b0;
      cs_q        <= 1'b1;
      bit_cnt     <= '0;
      byte_cnt    <= '0;
      rx_sh       <= '0;
      tx_sh       <= '0;
      lo_q        <= '0;
      hi_q        <= '0;
      reg_q       <= '0;
      rd_q        <= 1'b0;
      frame_valid <= 1'b0;
    end else begin
      sclk_q      <= sclk_s;
      cs_q        <= cs_n_s;
      frame_valid <= 1'b0;
      if (cs_fall) begin
        bit_cnt  <= '0;
        byte_cnt <= '0;
        tx_sh    <= '0;
      end else if (cs_rise) begin
        frame_valid <= (byte_cnt == 3'(FRAME_BYTES));
      end else if (active) begin
        if (rise) begin
          rx_sh   <= rx_byte[BYTE_W-2:0];
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            case (byte_cnt)
              3'd0: begin
                reg_q <= rx_byte[1:0];
                rd_q  <= rx_byte[DIR_BIT];
              end
              3'd1:    lo_q <= rx_byte;
              3'd2:    hi_q <= rx_byte;
              default: ;
            endcase
            if (byte_cnt != 3'(FRAME_BYTES + 1)) byte_cnt <= byte_cnt + 3'd1;
          end
        end else if (fall) begin
          if (bit_cnt == 3'd0) begin
            case (byte_cnt)
              3'd1:    tx_sh <= reply_word[BYTE_W-1:0];
              3'd2:    tx_sh <= reply_word[WORD_W-1:BYTE_W];
              default: tx_sh <= '0;
            endcase
          end else begin
            tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
          end
        end
      end
    end
  end

  assign miso       = active & tx_sh[BYTE_W-1];
  assign cur_reg    = reg_q;
  assign frame_reg  = reg_q;
  assign frame_rd   = rd_q;
  assign frame_data = {hi_q, lo_q};
endmodule

// File: rtl/spi_regbridge_regs.sv
module spi_regbridge_regs
  import spi_regbridge_pkg::*;
#(
  parameter int ADDR_HI_W = 8,
  parameter int SEL_W = 2,
  localparam int ADDR_W = WORD_W + ADDR_HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_valid,
  input  logic [1:0]        frame_reg,
  input  logic              frame_rd,
  input  logic [WORD_W-1:0] frame_data,
  input  logic [1:0]        cur_reg,
  output logic [WORD_W-1:0] reply_word,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [SEL_W-1:0]  bus_sel,
  output logic [WORD_W-1:0] bus_wdata,
  input  logic [WORD_W-1:0] bus_rdata,
  input  logic              bus_done
);
  logic [WORD_W-1:0]    addr_lo;
  logic [ADDR_HI_W-1:0] addr_hi;
  logic [SEL_W-1:0]     bank;
  logic [WORD_W-1:0]    hold;
  logic                 port_hit;

  assign port_hit = frame_valid && (breg_e'(frame_reg) == BREG_PORT) && !bus_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_lo   <= '0;
      addr_hi   <= '0;
      bank      <= '0;
      hold      <= '0;
      bus_req   <= 1'b0;
      bus_we    <= 1'b0;
      bus_addr  <= '0;
      bus_sel   <= '0;
      bus_wdata <= '0;
    end else begin
      if (frame_valid && !frame_rd) begin
        case (breg_e'(frame_reg))
          BREG_ADDR_LO: addr_lo <= frame_data;
          BREG_ADDR_HI: addr_hi <= frame_data[ADDR_HI_W-1:0];
          BREG_BANK:    bank    <= frame_data[SEL_W-1:0];
          default:      ;
        endcase
      end
      if (port_hit) begin
        bus_req   <= 1'b1;
        bus_we    <= !frame_rd;
        bus_addr  <= {addr_hi, addr_lo};
        bus_sel   <= bank;
        bus_wdata <= frame_data;
      end else if (bus_req && bus_done) begin
        bus_req <= 1'b0;
        if (!bus_we) hold <= bus_rdata;
      end
    end
  end

  always_comb begin
    reply_word = '0;
    case (breg_e'(cur_reg))
      BREG_ADDR_LO: reply_word = addr_lo;
      BREG_ADDR_HI: reply_word[ADDR_HI_W-1:0] = addr_hi;
      BREG_BANK:    reply_word[SEL_W-1:0] = bank;
      default:      reply_word = hold;
    endcase
  end
endmodule

// File: rtl/spi_regbridge.sv
module spi_regbridge
  import spi_regbridge_pkg::*;
#(
  parameter int ADDR_HI_W = 8,
  parameter int SEL_W = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    spi_sclk,
  input  logic                    spi_mosi,
  input  logic                    spi_cs_n,
  output logic                    spi_miso,
  output logic                    bus_req,
  output logic                    bus_we,
  output logic [ADDR_HI_W+15:0]   bus_addr,
  output logic [SEL_W-1:0]        bus_sel,
  output logic [15:0]             bus_wdata,
  input  logic [15:0]             bus_rdata,
  input  logic                    bus_done
);
  logic [2:0]        pins_s;
  logic [WORD_W-1:0] reply_word;
  logic [1:0]        cur_reg;
  logic              frame_valid;
  logic [1:0]        frame_reg;
  logic              frame_rd;
  logic [WORD_W-1:0] frame_data;

  spi_regbridge_sync #(
    .W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_cs_n, spi_mosi, spi_sclk}),
    .q(pins_s)
  );

  spi_regbridge_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(pins_s[0]), .mosi_s(pins_s[1]), .cs_n_s(pins_s[2]),
    .reply_word(reply_word),
    .miso(spi_miso),
    .cur_reg(cur_reg),
    .frame_valid(frame_valid),
    .frame_reg(frame_reg),
    .frame_rd(frame_rd),
    .frame_data(frame_data)
  );

  spi_regbridge_regs #(
    .ADDR_HI_W(ADDR_HI_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .frame_valid(frame_valid),
    .frame_reg(frame_reg),
    .frame_rd(frame_rd),
    .frame_data(frame_data),
    .cur_reg(cur_reg),
    .reply_word(reply_word),
    .bus_req(bus_req),
    .bus_we(bus_we),
    .bus_addr(bus_addr),
    .bus_sel(bus_sel),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .bus_done(bus_done)
  );
endmodule

// File: rtl/spi_regbridge_chk.sv
module spi_regbridge_chk #(
  parameter int ADDR_HI_W = 8,
  parameter int SEL_W = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_req,
  input logic                  bus_done,
  input logic                  bus_we,
  input logic [ADDR_HI_W+15:0] bus_addr,
  input logic [SEL_W-1:0]      bus_sel,
  input logic [15:0]           bus_wdata,
  input logic                  frame_valid,
  input logic [1:0]            frame_reg,
  input logic                  frame_rd
);
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> bus_req);

  assert_bus_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_done) |=> ($stable(bus_we) && $stable(bus_addr) &&
                                $stable(bus_sel) && $stable(bus_wdata)));

  assert_req_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_done) |=> !bus_req);

  assert_launch_from_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> ($past(frame_valid) && $past(frame_reg) == 2'd3));

  assert_direction_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> (bus_we == !$past(frame_rd)));
endmodule

bind spi_regbridge spi_regbridge_chk #(.ADDR_HI_W(ADDR_HI_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .bus_req(bus_req), .bus_done(bus_done), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
  .frame_valid(frame_valid), .frame_reg(frame_reg), .frame_rd(frame_rd)
);

// File: tb/spi_regbridge_test.sv
module spi_regbridge_test;
  localparam int HALF = 8;
  localparam int GAP  = 24;
  localparam int LAT  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic        miso, bus_req, bus_we, bus_done;
  logic [23:0] bus_addr;
  logic [1:0]  bus_sel;
  logic [15:0] bus_wdata, bus_rdata;

  typedef struct packed {
    logic        we;
    logic [23:0] addr;
    logic [1:0]  sel;
    logic [15:0] data;
  } busop_t;

  busop_t sb_q[$];
  int checks = 0, fails = 0, bus_ops = 0, early_drops = 0;

  function automatic logic [15:0] model_rd(logic [23:0] a, logic [1:0] s);
    return a[15:0] ^ 16'hC3A5 ^ {s, 6'd0, a[23:16]};
  endfunction

  assign bus_rdata = model_rd(bus_addr, bus_sel);

  spi_regbridge uut (
    .clk(clk), .rst_n(rst_n),
    .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n), .spi_miso(miso),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_done(bus_done)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // parallel bus responder
  int lat_cnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      lat_cnt <= 0;
      bus_done <= 1'b0;
    end else if (bus_req && !bus_done) begin
      if (lat_cnt == LAT - 1) begin
        bus_done <= 1'b1;
        lat_cnt <= 0;
      end else lat_cnt <= lat_cnt + 1;
    end else bus_done <= 1'b0;
  end

  // scoreboard monitor
  logic prev_req = 1'b0, prev_done = 1'b0;
  always @(negedge clk) begin : monitor
    busop_t got, exp;
    if (rst_n) begin
      if (prev_req && !bus_req && !prev_done) early_drops++;
      if (bus_req && bus_done) begin
        got = '{we: bus_we, addr: bus_addr, sel: bus_sel,
                data: bus_we ? bus_wdata : 16'h0};
        bus_ops++;
        if (sb_q.size() == 0) begin
          checks++;
          fails++;
          $display("FAIL R8 unexpected bus cycle actual=%0h expected=none", got);
        end else begin
          exp = sb_q.pop_front();
          chk(bus_we ? "R5 bus write" : "R6 bus read", 64'(got), 64'(exp));
        end
      end
    end
    prev_req  = bus_req;
    prev_done = bus_done;
  end

  // SPI host driver
  logic [15:0] sh_lo = 16'h0;
  logic [7:0]  sh_hi = 8'h0;
  logic [1:0]  sh_sel = 2'h0;

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic spi_frame(input logic [7:0] cmd, input logic [15:0] data,
                           input int nbytes, output logic [7:0] r0,
                           output logic [15:0] rw);
    logic [7:0] b1, b2, bx;
    b1 = 8'h0;
    b2 = 8'h0;
    @(negedge clk);
    cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_byte(cmd, r0);
    if (nbytes > 1) spi_byte(data[7:0], b1);
    if (nbytes > 2) spi_byte(data[15:8], b2);
    if (nbytes > 3) spi_byte(8'h3C, bx);
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (GAP) @(negedge clk);
    rw = {b2, b1};
  endtask

  task automatic port_write(input logic [15:0] data);
    logic [7:0] r0;
    logic [15:0] rw;
    sb_q.push_back('{we: 1'b1, addr: {sh_hi, sh_lo}, sel: sh_sel, data: data});
    spi_frame(8'h03, data, 3, r0, rw);
  endtask

  task automatic port_read(output logic [15:0] rw);
    logic [7:0] r0;
    sb_q.push_back('{we: 1'b0, addr: {sh_hi, sh_lo}, sel: sh_sel, data: 16'h0});
    spi_frame(8'h0B, 16'h0, 3, r0, rw);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin : main
    logic [7:0]  r0;
    logic [15:0] rw;
    int ops_before;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    chk("R1 miso low after reset", 64'(miso), 64'h0);
    chk("R1 bus_req low after reset", 64'(bus_req), 64'h0);
    spi_frame(8'h08, 16'h0, 3, r0, rw);
    chk("R1 addr low reset", 64'(rw), 64'h0);
    chk("R10 command reply byte", 64'(r0), 64'h0);
    spi_frame(8'h09, 16'h0, 3, r0, rw);
    chk("R1 addr high reset", 64'(rw), 64'h0);
    spi_frame(8'h0A, 16'h0, 3, r0, rw);
    chk("R1 chip-select reset", 64'(rw), 64'h0);

    // R3 / R4: write and read back
    spi_frame(8'h00, 16'h01FE, 3, r0, rw);
    spi_frame(8'h08, 16'h0, 3, r0, rw);
    chk("R4 low byte first readback", 64'(rw), 64'h01FE);
    spi_frame(8'h00, 16'h1234, 3, r0, rw);
    sh_lo = 16'h1234;
    spi_frame(8'h01, 16'hABCD, 3, r0, rw);
    sh_hi = 8'hCD;
    spi_frame(8'h02, 16'hFFFF, 3, r0, rw);
    sh_sel = 2'h3;
    spi_frame(8'h08, 16'h0, 3, r0, rw);
    chk("R3 addr low readback", 64'(rw), 64'h1234);
    spi_frame(8'h09, 16'h0, 3, r0, rw);
    chk("R3 addr high 8-bit readback", 64'(rw), 64'h00CD);
    spi_frame(8'h0A, 16'h0, 3, r0, rw);
    chk("R3 chip-select 2-bit readback", 64'(rw), 64'h0003);
    chk("R10 command reply byte on read", 64'(r0), 64'h0);

    // R2: unused command bits ignored
    spi_frame(8'hF4, 16'h5678, 3, r0, rw);
    sh_lo = 16'h5678;
    spi_frame(8'hFC, 16'h0, 3, r0, rw);
    chk("R2 extra command bits ignored", 64'(rw), 64'h5678);

    // R5 / R7: data-port writes
    ops_before = bus_ops;
    port_write(16'hBEEF);
    chk("R5 one bus write issued", 64'(bus_ops - ops_before), 64'h1);
    port_write(16'h0102);
    chk("R7 second write reuses location", 64'(sb_q.size()), 64'h0);

    // R6: pipelined reads
    port_read(rw);
    chk("R6 first read returns previous result", 64'(rw), 64'h0);
    port_read(rw);
    chk("R6 second read returns fresh data", 64'(rw), 64'(model_rd({8'hCD, 16'h5678}, 2'h3)));
    spi_frame(8'h00, 16'h0F0F, 3, r0, rw);
    sh_lo = 16'h0F0F;
    spi_frame(8'h02, 16'h0001, 3, r0, rw);
    sh_sel = 2'h1;
    port_read(rw);
    chk("R6 read after move returns stale data", 64'(rw), 64'(model_rd({8'hCD, 16'h5678}, 2'h3)));
    port_read(rw);
    chk("R6 read after move returns new data", 64'(rw), 64'(model_rd({8'hCD, 16'h0F0F}, 2'h1)));

    // R8: malformed frames
    spi_frame(8'h00, 16'h9999, 2, r0, rw);
    spi_frame(8'h08, 16'h0, 3, r0, rw);
    chk("R8 short frame leaves register", 64'(rw), 64'h0F0F);
    spi_frame(8'h00, 16'h7777, 4, r0, rw);
    spi_frame(8'h08, 16'h0, 3, r0, rw);
    chk("R8 long frame leaves register", 64'(rw), 64'h0F0F);
    ops_before = bus_ops;
    spi_frame(8'h03, 16'h4444, 2, r0, rw);
    spi_frame(8'h0B, 16'h0, 1, r0, rw);
    chk("R8 short port frames start no cycle", 64'(bus_ops - ops_before), 64'h0);

    repeat (20) @(negedge clk);
    chk("R5 all expected bus cycles seen", 64'(sb_q.size()), 64'h0);
    chk("R9 no early request drop", 64'(early_drops), 64'h0);
    chk("R9 request idle at end", 64'(bus_req), 64'h0);
    finish_run();
  end
endmodule